// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block sits between the waveform generator of a timer and one general-purpose port pin. It keeps a one-bit compare state register. On a compare-match strobe, or on a software force strobe, the register is changed according to a two-bit output-mode field. The same field decides whether the compare state replaces the port's ordinary data bit on the pin.

The pin direction always comes from the port direction bit, so the compare state is kept apart from the pin itself. Software can therefore preset the compare state while the pin is still an input. When the direction bit is later set, the pin drives a known level from its first cycle.

A waveform-mode select tells the unit whether the timer runs in a non-PWM or a PWM mode. In PWM mode the force strobe has no effect.

Top module: `oc_pin_unit`

## Requirements
- R1: A synchronous active-high reset clears the compare state to 0, so after reset the pin reads 0 while the override is active and the pin is an output.
- R2: When the mode field is nonzero, the pin value is the compare state. When the mode field is 00, the pin value is the port data bit.
- R3: The pin output-enable always equals the port direction bit, whatever the mode field holds.
- R4: When the direction bit is 0, the pin is released: output-enable is low and the pin value is 0, whatever the port data bit or the compare state holds.
- R5: With the mode field at 00, neither a match nor a force changes the compare state, in either waveform mode.
- R6: In non-PWM mode (waveform select 0), a match updates the compare state one clock later. Mode 01 inverts it, mode 10 clears it to 0 and mode 11 sets it to 1.
- R7: In non-PWM mode, a force strobe applies the same action as a match. A force and a match in the same cycle apply the action only once, so a toggle inverts the state a single time.
- R8: In PWM mode (waveform select 1), a force strobe leaves the compare state unchanged.
- R9: A compare state set up with force while the direction bit is 0 appears on the pin in the same cycle the direction bit becomes 1.
- R10: In PWM mode, a match with a nonzero mode field applies the same toggle, clear or set action as in non-PWM mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | 1 | Compare-match strobe from the comparator |
| mode_i | input | 2 | Output mode: 00 off, 01 toggle, 10 clear, 11 set |
| force_i | input | 1 | Force-compare strobe |
| pwm_i | input | 1 | Waveform select: 0 non-PWM, 1 PWM |
| port_data_i | input | 1 | Ordinary port data bit |
| port_dir_i | input | 1 | Port direction bit (1 = output) |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin output-enable |

## Verification
The bench targets a force and a match in the same cycle with mode toggle. A design that adds the two events would invert twice and leave the state unchanged. It drives a force in PWM mode, which a careless gate would let through, and strikes with mode 00, where a decoder that treats 00 as clear would zero the state. It also presets the state while the pin is an input and then enables it: a mux that ignores the direction bit, or lets port data leak through, shows the wrong level in that first driven cycle. Random stimulus then checks the pin and output-enable against a bench model on every cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        OCM_OFF    = 2'b00,
        OCM_TOGGLE = 2'b01,
        OCM_CLEAR  = 2'b10,
        OCM_SET    = 2'b11
    } ocm_e;

    typedef enum logic {
        WG_NONPWM = 1'b0,
        WG_PWM    = 1'b1
    } wg_e;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_ctrl_t;

    function automatic logic next_state(input ocm_e mode, input logic cur);
        case (mode)
            OCM_TOGGLE: next_state = ~cur;
            OCM_CLEAR:  next_state = 1'b0;
            OCM_SET:    next_state = 1'b1;
            default:    next_state = cur;
        endcase
    endfunction

    function automatic logic takes_pin(input ocm_e mode);
        takes_pin = (mode != OCM_OFF);
    endfunction

endpackage

// File: rtl/oc_event_gate.sv
module oc_event_gate
    import oc_pkg::*;
(
    input  logic match_i,
    input  logic force_i,
    input  wg_e  wg_i,
    input  ocm_e mode_i,
    output logic fire_o
);
    logic force_ok;

    always_comb begin
        force_ok = force_i && (wg_i == WG_NONPWM);
        fire_o   = (match_i || force_ok) && (mode_i != OCM_OFF);
    end
endmodule

// File: rtl/oc_state_reg.sv
module oc_state_reg
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    input  ocm_e mode_i,
    input  logic match_i,
    input  logic force_i,
    input  wg_e  wg_i,
    output logic state_o
);
    logic state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= 1'b0;
        else if (fire_i)
            state_q <= next_state(mode_i, state_q);
    end

    assign state_o = state_q;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == 1'b0));

    assert_off_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_i == OCM_OFF) |=> (state_q == $past(state_q)));

    assert_set_action_R6: assert property (@(posedge clk) disable iff (rst)
        ((match_i || (force_i && wg_i == WG_NONPWM)) && mode_i == OCM_SET) |=> state_q);

    assert_clear_action_R6: assert property (@(posedge clk) disable iff (rst)
        ((match_i || (force_i && wg_i == WG_NONPWM)) && mode_i == OCM_CLEAR) |=> !state_q);

    assert_toggle_once_R7: assert property (@(posedge clk) disable iff (rst)
        ((match_i || (force_i && wg_i == WG_NONPWM)) && mode_i == OCM_TOGGLE)
        |=> (state_q != $past(state_q)));

    assert_pwm_force_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (wg_i == WG_PWM && force_i && !match_i) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/oc_pin_mux.sv
module oc_pin_mux
    import oc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ocm_e      mode_i,
    input  logic      state_i,
    input  logic      port_data_i,
    input  logic      port_dir_i,
    output pin_ctrl_t pin_o
);
    logic src;

    always_comb begin
        src         = takes_pin(mode_i) ? state_i : port_data_i;
        pin_o.drive = port_dir_i;
        pin_o.level = port_dir_i ? src : 1'b0;
    end

    assert_released_low_R4: assert property (@(posedge clk) disable iff (rst)
        !port_dir_i |-> (!pin_o.drive && !pin_o.level));

    assert_override_R2: assert property (@(posedge clk) disable iff (rst)
        (port_dir_i && mode_i != OCM_OFF) |-> (pin_o.level == state_i));

    assert_port_data_R2: assert property (@(posedge clk) disable iff (rst)
        (port_dir_i && mode_i == OCM_OFF) |-> (pin_o.level == port_data_i));
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       match_i,
    input  logic [1:0] mode_i,
    input  logic       force_i,
    input  logic       pwm_i,
    input  logic       port_data_i,
    input  logic       port_dir_i,
    output logic       pin_o,
    output logic       pin_oe_o
);
    ocm_e      mode;
    wg_e       wg;
    logic      fire;
    logic      state;
    pin_ctrl_t ctrl;

    assign mode = ocm_e'(mode_i);
    assign wg   = wg_e'(pwm_i);

    oc_event_gate u_gate (
        .match_i (match_i),
        .force_i (force_i),
        .wg_i    (wg),
        .mode_i  (mode),
        .fire_o  (fire)
    );

    oc_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .mode_i  (mode),
        .match_i (match_i),
        .force_i (force_i),
        .wg_i    (wg),
        .state_o (state)
    );

    oc_pin_mux u_mux (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .state_i     (state),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pin_o       (ctrl)
    );

    assign pin_o    = ctrl.level;
    assign pin_oe_o = ctrl.drive;

    assert_oe_is_dir_R3: assert property (@(posedge clk) disable iff (rst)
        pin_oe_o == port_dir_i);

    assert_pwm_match_set_R10: assert property (@(posedge clk) disable iff (rst)
        (pwm_i && match_i && mode_i == 2'b11) |=> pin_o || !port_dir_i || mode_i == 2'b00
        || (mode_i != 2'b11 && mode_i != 2'b00 && 1'b1));
endmodule

// File: tb/sim_oc_pin_unit.sv
module sim_oc_pin_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic match = 1'b0, frc = 1'b0, pwm = 1'b0, pdata = 1'b0, pdir = 1'b0;
    logic [1:0] mode = 2'b00;
    logic pin, oe;

    int total = 0;
    int bad = 0;
    logic model_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_pin_unit u0 (
        .clk(clk), .rst(rst), .match_i(match), .mode_i(mode), .force_i(frc),
        .pwm_i(pwm), .port_data_i(pdata), .port_dir_i(pdir),
        .pin_o(pin), .pin_oe_o(oe)
    );

    function automatic logic model_next(input logic s, input logic [1:0] md,
                                        input logic m, input logic f, input logic p);
        logic hit;
        hit = (md != 2'b00) && (m || (f && !p));
        if (!hit) return s;
        case (md)
            2'b01:   return ~s;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic model_pin(input logic s, input logic [1:0] md,
                                       input logic d, input logic dr);
        if (!dr) return 1'b0;
        return (md != 2'b00) ? s : d;
    endfunction

    task automatic chk(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input logic m, input logic [1:0] md, input logic f,
                        input logic p, input logic d, input logic dr);
        match = m; mode = md; frc = f; pwm = p; pdata = d; pdir = dr;
        @(posedge clk);
        if (rst) model_q = 1'b0;
        else     model_q = model_next(model_q, md, m, f, p);
        #(CLK_PERIOD/4);
        match = 1'b0; frc = 1'b0;
    endtask

    task automatic chk_pins(input string req);
        chk(pin, model_pin(model_q, mode, pdata, pdir), req);
        chk(oe, pdir, "R3");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog: got=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with override on and pin as output
        rst = 1'b1;
        step(1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
        rst = 1'b0;
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(pin, 1'b0, "R1");
        chk(oe, 1'b1, "R3");

        // R6: set, toggle, clear in non-PWM
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(pin, 1'b1, "R6");
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(pin, 1'b0, "R6");
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(pin, 1'b1, "R6");
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(pin, 1'b0, "R6");

        // R5: mode 00 with match and force leaves state, pin shows port data
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(pin, 1'b0, "R2");
        step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1);
        mode = 2'b11; #1;
        chk(pin, 1'b1, "R5");

        // R7: force plus match with toggle inverts once
        step(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1);
        chk(pin, 1'b0, "R7");
        step(1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(pin, 1'b1, "R7");

        // R8: force ignored in PWM mode
        step(1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);
        chk(pin, 1'b1, "R8");
        step(1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1);
        chk(pin, 1'b1, "R8");

        // R10: PWM match applies action
        step(1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(pin, 1'b0, "R10");
        step(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1);
        chk(pin, 1'b1, "R10");

        // R4 and R9: preset while input, then enable
        step(1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(pin, 1'b0, "R4");
        chk(oe, 1'b0, "R4");
        step(1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(pin, 1'b0, "R4");
        pdir = 1'b1; #1;
        chk(pin, 1'b1, "R9");
        chk(oe, 1'b1, "R3");
        step(1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0);
        pdir = 1'b1; #1;
        chk(pin, 1'b0, "R9");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[2:1], r[3], r[4], r[5], r[6] | r[7]);
            if (!pdir)               chk_pins("R4");
            else if (mode == 2'b00)  chk_pins("R2");
            else if (pwm)            chk_pins("R10");
            else                     chk_pins("R6");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule